// File: doc/BRIEF.md
# Video Interrupt and Frame-Lock Detector

This block merges two video event sources into one interrupt line. The first source is a strobe from the mode-selection logic. It pulses once when the mode-match result is rewritten because a new mode was chosen. The second source is built into the block. It is an alignment detector that watches the frame-start pulse of the generated output and the frame-start pulse of the incoming reference. It reports the moment the two first coincide.

Software uses a small register port with two registers:

- **Control register:** enables each source onto the interrupt line.
- **Status register:** holds the latched events. Each status bit is cleared by writing a one to it.

Each status bit records its event whether or not that source is enabled. The enables only gate the interrupt output. The timing generator and the mode bank are outside this block.

Top module: `vid_irq_lock_top`

## Requirements
- R1: After a synchronous reset, the control register (offset 0) and the status register (offset 1) both read zero, and `irq` is low.
- R2: A one-cycle pulse on `mode_upd` sets status bit 1. The bit reads as one from the cycle after the pulse.
- R3: When `sof_gen` and `sof_ref` are high in the same cycle while the detector is unaligned, status bit 2 is set from the next cycle on. The detector then becomes aligned.
- R4: While the detector stays aligned, further coincident frame-start pulses do not set status bit 2 again.
- R5: A cycle where exactly one of `sof_gen` or `sof_ref` is high returns the detector to unaligned. The next coincidence sets status bit 2 again.
- R6: Writing the control register stores write-data bits [2:1] as the enables: bit 1 for the mode-update source and bit 2 for the lock source. Reading the control register returns them in the same positions, with every other bit zero.
- R7: `irq` is high exactly when a status bit is set and its enable bit is set. Status bits latch events even when their enables are off.
- R8: Writing the status register with a one in bit 1 or bit 2 clears that status bit. A zero in that position leaves the bit unchanged.
- R9: When an event arrives in the same cycle as a clearing write to its status bit, the bit stays set.
- R10: Any register offset other than 0 and 1 reads as zero. Writes to such an offset change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_upd | input | 1 | Pulse: mode-match result was updated |
| sof_gen | input | 1 | Frame-start pulse of the generated output |
| sof_ref | input | 1 | Frame-start pulse of the incoming reference |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt line |

## Verification
A status bit that failed to latch, or that cleared on a zero write, shows up on `reg_rdata` at the status offset one cycle after the event or the write. It also changes `irq` in that same cycle whenever the source is enabled. An alignment detector stuck in the wrong state shows up only at the next coincident frame-start pair, as a missing or extra lock event. For that reason the bench drives lone pulses and coincident pulses back to back, and compares both outputs against its model every cycle.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int NUM_SRC  = 2;
    localparam int EVT_LSB  = 1;
    localparam int IDX_MODE = 0;
    localparam int IDX_LOCK = 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] place_bits(input src_vec_t v);
        return DATA_W'(v) << EVT_LSB;
    endfunction

    function automatic src_vec_t pick_bits(input logic [DATA_W-1:0] d);
        return d[EVT_LSB +: NUM_SRC];
    endfunction
endpackage

// File: rtl/sof_align_det.sv
module sof_align_det (
    input  logic clk,
    input  logic rst,
    input  logic sof_gen_i,
    input  logic sof_ref_i,
    output logic lock_evt_o
);
    logic aligned_q;
    logic both;
    logic lone;

    assign both       = sof_gen_i & sof_ref_i;
    assign lone       = sof_gen_i ^ sof_ref_i;
    assign lock_evt_o = both & ~aligned_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned_q <= 1'b0;
        end else if (both) begin
            aligned_q <= 1'b1;
        end else if (lone) begin
            aligned_q <= 1'b0;
        end
    end

    assert_coincide_aligns_R3: assert property (@(posedge clk) disable iff (rst)
        (sof_gen_i && sof_ref_i) |=> aligned_q);
    assert_lone_unaligns_R5: assert property (@(posedge clk) disable iff (rst)
        (sof_gen_i != sof_ref_i) |=> !aligned_q);
    assert_no_repeat_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (sof_gen_i && sof_ref_i && $past(sof_gen_i && sof_ref_i)) |-> !lock_evt_o);
endmodule

// File: rtl/irq_evt_bit.sv
module irq_evt_bit (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic clr_i,
    output logic stat_o
);
    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
        end else if (evt_i) begin
            stat_q <= 1'b1;
        end else if (clr_i) begin
            stat_q <= 1'b0;
        end
    end

    assign stat_o = stat_q;

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> stat_q);
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> !stat_q);
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !evt_i) |=> $stable(stat_q));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import vid_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  src_vec_t          stat_i,
    output src_vec_t          en_o,
    output src_vec_t          clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    src_vec_t en_q;
    logic     hit_ctrl;
    logic     hit_stat;

    assign hit_ctrl = wr_i && (addr_i == REG_CTRL);
    assign hit_stat = wr_i && (addr_i == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (hit_ctrl) begin
            en_q <= pick_bits(wdata_i);
        end
    end

    assign clr_o = hit_stat ? pick_bits(wdata_i) : '0;
    assign en_o  = en_q;

    always_comb begin
        rdata_o = '0;
        if (addr_i == REG_CTRL) begin
            rdata_o = place_bits(en_q);
        end else if (addr_i == REG_STAT) begin
            rdata_o = place_bits(stat_i);
        end
    end

    assert_ctrl_store_R6: assert property (@(posedge clk) disable iff (rst)
        hit_ctrl |=> (en_q == pick_bits($past(wdata_i))));
    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !hit_ctrl |=> $stable(en_q));
endmodule

// File: rtl/vid_irq_lock_top.sv
module vid_irq_lock_top
    import vid_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_upd,
    input  logic              sof_gen,
    input  logic              sof_ref,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    src_vec_t evt;
    src_vec_t clr;
    src_vec_t stat;
    src_vec_t en;
    logic     lock_evt;

    sof_align_det u_align (
        .clk        (clk),
        .rst        (rst),
        .sof_gen_i  (sof_gen),
        .sof_ref_i  (sof_ref),
        .lock_evt_o (lock_evt)
    );

    always_comb begin
        evt           = '0;
        evt[IDX_MODE] = mode_upd;
        evt[IDX_LOCK] = lock_evt;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_evt_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .evt_i  (evt[g]),
            .clr_i  (clr[g]),
            .stat_o (stat[g])
        );
    end

    irq_reg_port u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .stat_i  (stat),
        .en_o    (en),
        .clr_o   (clr),
        .rdata_o (reg_rdata)
    );

    assign irq = |(en & stat);

    assert_mode_sets_R2: assert property (@(posedge clk) disable iff (rst)
        mode_upd |=> stat[IDX_MODE]);
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);
endmodule

// File: tb/vid_irq_lock_top_test.sv
module vid_irq_lock_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_upd = 1'b0;
    logic        sof_gen = 1'b0;
    logic        sof_ref = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    bit [1:0] m_en = 2'b00;
    bit [1:0] m_st = 2'b00;
    bit       m_al = 1'b0;

    always #5 clk = ~clk;

    vid_irq_lock_top uut (
        .clk(clk), .rst(rst), .mode_upd(mode_upd), .sof_gen(sof_gen),
        .sof_ref(sof_ref), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit       lock;
        bit [1:0] clr;
        if (rst) begin
            m_en = 2'b00; m_st = 2'b00; m_al = 1'b0;
        end else begin
            lock = sof_gen && sof_ref && !m_al;
            if (sof_gen && sof_ref) m_al = 1'b1;
            else if (sof_gen || sof_ref) m_al = 1'b0;
            clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[2:1] : 2'b00;
            m_st[0] = mode_upd ? 1'b1 : (clr[0] ? 1'b0 : m_st[0]);
            m_st[1] = lock     ? 1'b1 : (clr[1] ? 1'b0 : m_st[1]);
            if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[2:1];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        if (a == 2'd0) return {29'd0, m_en, 1'b0};
        if (a == 2'd1) return {29'd0, m_st, 1'b0};
        return 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic mu, input logic sg, input logic sr,
                       input logic wr, input logic [1:0] ad, input logic [31:0] wd);
        @(negedge clk);
        if (!rst) begin
            check({cur_req, " irq"}, {31'd0, irq}, {31'd0, |(m_en & m_st)});
            check({cur_req, " rdata"}, reg_rdata, exp_rd(reg_addr));
        end
        mode_upd = mu; sof_gen = sg; sof_ref = sr;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    endtask

    task automatic rd_check(input string req, input logic [1:0] ad, input logic [31:0] exp);
        cur_req = req;
        cyc(0, 0, 0, 0, ad, 32'd0);
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        #1;
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_check("R1", 2'd0, 32'd0);
        rd_check("R1", 2'd1, 32'd0);
        irq_check("R1", 1'b0);

        cur_req = "R2"; cyc(1, 0, 0, 0, 2'd1, 0);
        rd_check("R2", 2'd1, 32'h2);
        irq_check("R7", 1'b0);                 // latched, but masked

        cur_req = "R6"; cyc(0, 0, 0, 1, 2'd0, 32'h7);
        rd_check("R6", 2'd0, 32'h6);
        irq_check("R7", 1'b1);

        cur_req = "R8"; cyc(0, 0, 0, 1, 2'd1, 32'h0);
        rd_check("R8", 2'd1, 32'h2);
        cur_req = "R8"; cyc(0, 0, 0, 1, 2'd1, 32'h2);
        rd_check("R8", 2'd1, 32'h0);
        irq_check("R8", 1'b0);

        cur_req = "R3"; cyc(0, 1, 1, 0, 2'd1, 0);
        rd_check("R3", 2'd1, 32'h4);
        irq_check("R7", 1'b1);

        cur_req = "R4"; cyc(0, 0, 0, 1, 2'd1, 32'h4);
        cyc(0, 1, 1, 0, 2'd1, 0);
        cyc(0, 1, 1, 0, 2'd1, 0);
        rd_check("R4", 2'd1, 32'h0);

        cur_req = "R5"; cyc(0, 1, 0, 0, 2'd1, 0);
        cyc(0, 0, 1, 0, 2'd1, 0);
        rd_check("R5", 2'd1, 32'h0);
        cur_req = "R5"; cyc(0, 1, 1, 0, 2'd1, 0);
        rd_check("R5", 2'd1, 32'h4);

        cur_req = "R9"; cyc(1, 0, 0, 1, 2'd1, 32'h6);
        rd_check("R9", 2'd1, 32'h2);

        cur_req = "R10"; cyc(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        rd_check("R10", 2'd3, 32'h0);
        rd_check("R10", 2'd0, 32'h6);
        rd_check("R10", 2'd1, 32'h2);

        cur_req = "R7"; cyc(0, 0, 0, 1, 2'd0, 32'h0);
        rd_check("R7", 2'd1, 32'h2);
        irq_check("R7", 1'b0);

        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[2], r[3] | r[4], r[5] & r[6], r[8:7], {29'd0, r[11:9]});
        end
        cyc(0, 0, 0, 0, 2'd0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule